// File: doc/BRIEF.md
# Accumulator ALU With Status Flags

This block is the arithmetic and logic unit for an accumulator-based datapath. An operation arrives as a 4-bit code with the current accumulator value, the secondary register value, a second operand and the incoming carry, auxiliary carry and overflow flags. The block returns the new accumulator value, a new secondary register value, and a full set of flags including even parity of the result. It is used by raising `start_i` for one clock with the inputs valid. The block then pulses `done_o` when the results are ready, and it holds them on its outputs until the next operation completes.

Single-cycle operations cover add, add with carry, subtract with borrow, increment, decrement, AND, OR, XOR, complement and four rotates. Multiply and divide run in an iterative unit that handles one bit per clock. Their paired results go to the accumulator and the secondary register. While that unit is running, further starts are ignored.

Top module: `acc_alu`

## Requirements
- R1: After reset, `acc_o`, `regb_o`, all four flags and `done_o` are 0.
- R2: For codes other than 13 and 14, `done_o` is high in the cycle right after the rising edge that samples `start_i`. The outputs then hold their values, and `done_o` stays low, until another operation completes.
- R3: Code 0 (add) gives A+D. Code 1 (add with carry) gives A+D+C. The carry is the carry out of the top bit, the auxiliary carry is the carry out of bit 3, and overflow is signed two's-complement overflow.
- R4: Code 2 (subtract with borrow) gives A−D−C. The carry is set when a borrow occurs, the auxiliary carry is the borrow out of bit 3, and overflow is signed two's-complement overflow.
- R5: Code 3 (increment) and code 4 (decrement) wrap modulo 2^DATA_W and leave carry, auxiliary carry and overflow as they came in.
- R6: Codes 5, 6 and 7 give A AND D, A OR D and A XOR D. Code 8 gives the one's complement of A. All four leave carry, auxiliary carry and overflow unchanged.
- R7: Codes 9 and 10 rotate A left and right by one bit without using the carry. Codes 11 and 12 rotate left and right through the carry as a (DATA_W+1)-bit ring, with the carry taking the bit shifted out. The auxiliary carry and overflow are unchanged for all four.
- R8: Code 13 (multiply) puts the low half of A×B in the accumulator and the high half in B. It clears carry, sets overflow when the high half is nonzero, and keeps the auxiliary carry. `done_o` rises after the (DATA_W+1)th rising edge, counting the edge that samples `start_i`.
- R9: Code 14 (divide) puts the quotient A/B in the accumulator and the remainder in B, and clears carry and overflow. With B = 0 it sets overflow and clears carry, and the accumulator and B are then unspecified. It keeps the auxiliary carry and has the same latency as R8.
- R10: After every completed operation, `par_o` is the XOR of all bits of `acc_o`.
- R11: A start while a multiply or divide is in progress is ignored. Code 15 passes A, B and the flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation with the current inputs |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Current accumulator A |
| regb_i | input | DATA_W | Current secondary register B |
| opnd_i | input | DATA_W | Second operand D |
| cy_i | input | 1 | Incoming carry / borrow flag C |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| acc_o | output | DATA_W | New accumulator |
| regb_o | output | DATA_W | New secondary register |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary carry flag |
| ov_o | output | 1 | New overflow flag |
| par_o | output | 1 | Even parity of `acc_o` |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
The bench builds the block with DATA_W = 8. At that width the iterative unit takes a nine-edge latency, which is short enough to drive extra starts throughout a multiply and watch that exactly one completion appears. The byte width also makes the nibble boundary of the auxiliary carry and the sign bit at bit 7 separate bits. The hand-worked vectors (7Fh+1, 80h−1, 00h−1−1, FFh×FFh) therefore hit each flag on its own.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_ROLC = 4'd11,
        OP_RORC = 4'd12,
        OP_MUL  = 4'd13,
        OP_DIV  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    function automatic logic is_iterative(alu_op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

    function automatic logic is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_CPL);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] d_i,
    input  logic              cy_i,
    input  logic              ac_i,
    input  logic              ov_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic [NIB_W:0]  nib;
    logic            cin;

    always_comb begin
        wide  = '0;
        nib   = '0;
        cin   = 1'b0;
        res_o = a_i;
        cy_o  = cy_i;
        ac_o  = ac_i;
        ov_o  = ov_i;
        unique case (op_i)
            OP_ADD, OP_ADDC: begin
                cin   = (op_i == OP_ADDC) && cy_i;
                wide  = {1'b0, a_i} + {1'b0, d_i} + {{DATA_W{1'b0}}, cin};
                nib   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, d_i[NIB_W-1:0]}
                      + {{NIB_W{1'b0}}, cin};
                res_o = wide[DATA_W-1:0];
                cy_o  = wide[DATA_W];
                ac_o  = nib[NIB_W];
                ov_o  = (a_i[MSB] == d_i[MSB]) && (wide[MSB] != a_i[MSB]);
            end
            OP_SUBB: begin
                wide  = {1'b0, a_i} - {1'b0, d_i} - {{DATA_W{1'b0}}, cy_i};
                nib   = {1'b0, a_i[NIB_W-1:0]} - {1'b0, d_i[NIB_W-1:0]}
                      - {{NIB_W{1'b0}}, cy_i};
                res_o = wide[DATA_W-1:0];
                cy_o  = wide[DATA_W];
                ac_o  = nib[NIB_W];
                ov_o  = (a_i[MSB] != d_i[MSB]) && (wide[MSB] != a_i[MSB]);
            end
            OP_INC:  res_o = a_i + {{(DATA_W-1){1'b0}}, 1'b1};
            OP_DEC:  res_o = a_i - {{(DATA_W-1){1'b0}}, 1'b1};
            OP_AND:  res_o = a_i & d_i;
            OP_OR:   res_o = a_i | d_i;
            OP_XOR:  res_o = a_i ^ d_i;
            OP_CPL:  res_o = ~a_i;
            OP_ROL:  res_o = {a_i[MSB-1:0], a_i[MSB]};
            OP_ROR:  res_o = {a_i[0], a_i[MSB:1]};
            OP_ROLC: begin
                res_o = {a_i[MSB-1:0], cy_i};
                cy_o  = a_i[MSB];
            end
            OP_RORC: begin
                res_o = {cy_i, a_i[MSB:1]};
                cy_o  = a_i[0];
            end
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_div_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              fin_o,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              ovf_o
);

    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic                busy;
        logic                div;
        logic [CNT_W-1:0]    cnt;
        logic [2*DATA_W-1:0] p;
        logic [DATA_W-1:0]   b;
    } md_t;

    md_t md_d, md_q;

    logic [DATA_W:0]   msum;
    logic [DATA_W:0]   shv;
    logic [DATA_W:0]   diff;

    always_comb begin
        md_d  = md_q;
        msum  = {1'b0, md_q.p[2*DATA_W-1:DATA_W]}
              + (md_q.p[0] ? {1'b0, md_q.b} : '0);
        shv   = {md_q.p[2*DATA_W-1:DATA_W], md_q.p[DATA_W-1]};
        diff  = shv - {1'b0, md_q.b};
        fin_o = md_q.busy && (md_q.cnt == LAST);
        if (start_i) begin
            md_d.busy = 1'b1;
            md_d.div  = is_div_i;
            md_d.cnt  = '0;
            md_d.p    = {{DATA_W{1'b0}}, a_i};
            md_d.b    = b_i;
        end else if (md_q.busy) begin
            if (md_q.div) begin
                md_d.p[2*DATA_W-1:DATA_W] = diff[DATA_W] ? shv[DATA_W-1:0]
                                                         : diff[DATA_W-1:0];
                md_d.p[DATA_W-1:0]        = {md_q.p[DATA_W-2:0], ~diff[DATA_W]};
            end else begin
                md_d.p = {msum, md_q.p[DATA_W-1:1]};
            end
            md_d.cnt = md_q.cnt + 1'b1;
            if (fin_o) begin
                md_d.busy = 1'b0;
            end
        end
        lo_o  = md_d.p[DATA_W-1:0];
        hi_o  = md_d.p[2*DATA_W-1:DATA_W];
        ovf_o = md_q.div ? (md_q.b == '0) : (md_d.p[2*DATA_W-1:DATA_W] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= '0;
        end else begin
            md_q <= md_d;
        end
    end

    AST_MD_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !md_q.busy); // R11
    AST_MD_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !md_q.busy); // R8

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] regb_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              cy_i,
    input  logic              ac_i,
    input  logic              ov_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] regb_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              par_o,
    output logic              done_o
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] regb;
        logic              cy;
        logic              ac;
        logic              ov;
        logic              par;
        logic              done;
        logic              busy;
        logic              ac_hold;
    } st_t;

    st_t st_d, st_q;

    alu_op_e           op;
    logic              accept;
    logic              md_start;
    logic              md_fin;
    logic              md_ovf;
    logic [DATA_W-1:0] md_lo, md_hi;
    logic [DATA_W-1:0] ar_res;
    logic              ar_cy, ar_ac, ar_ov;

    assign op       = alu_op_e'(op_i);
    assign accept   = start_i && !st_q.busy;
    assign md_start = accept && is_iterative(op);

    acc_alu_arith #(.DATA_W(DATA_W), .NIB_W(4)) u_arith (
        .op_i  (op),
        .a_i   (acc_i),
        .d_i   (opnd_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .ov_i  (ov_i),
        .res_o (ar_res),
        .cy_o  (ar_cy),
        .ac_o  (ar_ac),
        .ov_o  (ar_ov)
    );

    acc_alu_muldiv #(.DATA_W(DATA_W)) u_muldiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (md_start),
        .is_div_i (op == OP_DIV),
        .a_i      (acc_i),
        .b_i      (regb_i),
        .fin_o    (md_fin),
        .lo_o     (md_lo),
        .hi_o     (md_hi),
        .ovf_o    (md_ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            if (is_iterative(op)) begin
                st_d.busy    = 1'b1;
                st_d.ac_hold = ac_i;
            end else begin
                st_d.acc  = ar_res;
                st_d.regb = regb_i;
                st_d.cy   = ar_cy;
                st_d.ac   = ar_ac;
                st_d.ov   = ar_ov;
                st_d.par  = ^ar_res;
                st_d.done = 1'b1;
            end
        end
        if (st_q.busy && md_fin) begin
            st_d.acc  = md_lo;
            st_d.regb = md_hi;
            st_d.cy   = 1'b0;
            st_d.ac   = st_q.ac_hold;
            st_d.ov   = md_ovf;
            st_d.par  = ^md_lo;
            st_d.done = 1'b1;
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign regb_o = st_q.regb;
    assign cy_o   = st_q.cy;
    assign ac_o   = st_q.ac;
    assign ov_o   = st_q.ov;
    assign par_o  = st_q.par;
    assign done_o = st_q.done;

    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_iterative(op)) |=> done_o); // R2
    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !md_fin) |=> !done_o); // R11
    AST_MD_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && md_fin) |=> (done_o && !cy_o)); // R8
    AST_BITWISE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_bitwise(op)) |=>
            (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i))); // R6
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (par_o == ^acc_o)); // R10

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    localparam int W       = 8;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 22;

    // {op4, a8, b8, d8, cy, ac, ov, expA8, expB8, ecy, eac, eov}
    localparam logic [49:0] VEC [NVEC] = '{
        {4'd0,  8'h3A, 8'h5A, 8'hC6, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b0},
        {4'd1,  8'h7F, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h5A, 1'b0, 1'b1, 1'b1},
        {4'd0,  8'h05, 8'h5A, 8'h03, 1'b0, 1'b0, 1'b0, 8'h08, 8'h5A, 1'b0, 1'b0, 1'b0},
        {4'd2,  8'h05, 8'h5A, 8'h03, 1'b1, 1'b0, 1'b0, 8'h01, 8'h5A, 1'b0, 1'b0, 1'b0},
        {4'd2,  8'h10, 8'h5A, 8'h01, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h5A, 1'b0, 1'b1, 1'b0},
        {4'd2,  8'h80, 8'h5A, 8'h01, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h5A, 1'b0, 1'b1, 1'b1},
        {4'd2,  8'h00, 8'h5A, 8'h01, 1'b1, 1'b0, 1'b0, 8'hFE, 8'h5A, 1'b1, 1'b1, 1'b0},
        {4'd3,  8'hFF, 8'h5A, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b1},
        {4'd4,  8'h00, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h5A, 1'b0, 1'b1, 1'b0},
        {4'd5,  8'hF0, 8'h5A, 8'h3C, 1'b1, 1'b0, 1'b1, 8'h30, 8'h5A, 1'b1, 1'b0, 1'b1},
        {4'd6,  8'hF0, 8'h5A, 8'h0F, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h5A, 1'b0, 1'b1, 1'b0},
        {4'd7,  8'hAA, 8'h5A, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h55, 8'h5A, 1'b1, 1'b1, 1'b0},
        {4'd8,  8'h3C, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b0, 1'b0, 1'b1},
        {4'd9,  8'h81, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 8'h5A, 1'b0, 1'b1, 1'b0},
        {4'd10, 8'h81, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, 8'hC0, 8'h5A, 1'b0, 1'b0, 1'b0},
        {4'd11, 8'h81, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 8'h5A, 1'b1, 1'b0, 1'b0},
        {4'd12, 8'h02, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, 8'h5A, 1'b0, 1'b0, 1'b0},
        {4'd13, 8'h07, 8'h02, 8'h00, 1'b1, 1'b1, 1'b1, 8'h0E, 8'h00, 1'b0, 1'b1, 1'b0},
        {4'd13, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'hFE, 1'b0, 1'b0, 1'b1},
        {4'd14, 8'h07, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1, 8'h03, 8'h01, 1'b0, 1'b0, 1'b0},
        {4'd14, 8'hFF, 8'h10, 8'h00, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h0F, 1'b0, 1'b1, 1'b0},
        {4'd15, 8'h12, 8'h34, 8'h77, 1'b1, 1'b0, 1'b1, 8'h12, 8'h34, 1'b1, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [3:0]   op_i = '0;
    logic [W-1:0] acc_i = '0, regb_i = '0, opnd_i = '0;
    logic         cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
    logic [W-1:0] acc_o, regb_o;
    logic         cy_o, ac_o, ov_o, par_o, done_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    acc_alu #(.DATA_W(W)) u_acc_alu (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .acc_i(acc_i), .regb_i(regb_i), .opnd_i(opnd_i),
        .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
        .acc_o(acc_o), .regb_o(regb_o), .cy_o(cy_o), .ac_o(ac_o),
        .ov_o(ov_o), .par_o(par_o), .done_o(done_o)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string rtag(logic [3:0] op);
        case (op)
            4'd0, 4'd1:                 return "R3";
            4'd2:                       return "R4";
            4'd3, 4'd4:                 return "R5";
            4'd5, 4'd6, 4'd7, 4'd8:     return "R6";
            4'd9, 4'd10, 4'd11, 4'd12:  return "R7";
            4'd13:                      return "R8";
            4'd14:                      return "R9";
            default:                    return "R11";
        endcase
    endfunction

    // Drive one operation; returns the number of rising edges from the
    // sampling edge up to the one after which done_o is seen high.
    task automatic run_op(input logic [3:0] op, input logic [W-1:0] a, b, d,
                          input logic c, x, v, output int edges);
        @(negedge clk);
        op_i = op; acc_i = a; regb_i = b; opnd_i = d;
        cy_i = c; ac_i = x; ov_i = v; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 40) begin
            @(posedge clk); #1;
            edges++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "acc", 16'(acc_o), 16'h0);
        chk("R1", "regb", 16'(regb_o), 16'h0);
        chk("R1", "flags", {12'h0, cy_o, ac_o, ov_o, par_o}, 16'h0);
        chk("R1", "done", 16'(done_o), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [49:0] v;
            int exp_lat;
            string t;
            v = VEC[i];
            t = rtag(v[49:46]);
            run_op(v[49:46], v[45:38], v[37:30], v[29:22],
                   v[21], v[20], v[19], lat);
            exp_lat = (v[49:46] == 4'd13 || v[49:46] == 4'd14) ? W + 1 : 1;
            chk(t, "latency", 16'(lat), 16'(exp_lat));
            chk(t, "acc", 16'(acc_o), 16'(v[18:11]));
            chk(t, "regb", 16'(regb_o), 16'(v[10:3]));
            chk(t, "cy/ac/ov", {13'h0, cy_o, ac_o, ov_o}, {13'h0, v[2:0]});
            chk("R10", "parity", 16'(par_o), 16'(^v[18:11]));
        end

        // R2: results held and no further done while idle
        run_op(4'd6, 8'h0C, 8'h21, 8'h30, 1'b0, 1'b0, 1'b0, lat);
        repeat (3) @(posedge clk);
        #1;
        chk("R2", "held acc", 16'(acc_o), 16'h3C);
        chk("R2", "held regb", 16'(regb_o), 16'h21);
        chk("R2", "done idle", 16'(done_o), 16'h0);

        // R9: divide by zero
        run_op(4'd14, 8'h33, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, lat);
        chk("R9", "div0 ov", 16'(ov_o), 16'h1);
        chk("R9", "div0 cy", 16'(cy_o), 16'h0);
        chk("R9", "div0 latency", 16'(lat), 16'(W + 1));

        // R11: starts while multiply runs are ignored
        begin
            int dones;
            dones = 0;
            @(negedge clk);
            op_i = 4'd13; acc_i = 8'h07; regb_i = 8'h02; opnd_i = 8'h00;
            cy_i = 1'b1; ac_i = 1'b0; ov_i = 1'b0; start_i = 1'b1;
            @(posedge clk); #1;
            op_i = 4'd0; acc_i = 8'h11; opnd_i = 8'h22;
            for (int k = 0; k < W; k++) begin
                @(posedge clk); #1;
                if (done_o) dones++;
            end
            start_i = 1'b0;
            @(posedge clk); #1;
            if (done_o) dones++;
            chk("R11", "done pulses", 16'(dones), 16'h1);
            chk("R11", "acc after busy starts", 16'(acc_o), 16'h0E);
            chk("R11", "regb after busy starts", 16'(regb_o), 16'h00);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule